// File: doc/BRIEF.md
# Banked Real-Time Clock with Latched Readout

This block keeps wall-clock time for a cartridge-style bus slave. A base tick input is divided down to one step per second. That step advances a seconds field, a minutes field, an hours field and a 9-bit day count. The day count sets a sticky carry flag when it wraps. A halt bit in the control register freezes all counting, including the sub-second phase.

The bus writer reaches the clock through four small regions:
- **Enable region:** gates access to the data window.
- **Bank-select region:** picks which clock register the window shows.
- **Latch region:** takes a two-write command that copies the live counters into a snapshot.
- **Data window:** reads return the snapshot. Writes go straight into the live counters.

The access gate is a two-state machine. `ACC_LOCKED` moves to `ACC_OPEN` on an enable value of 0x0A. `ACC_OPEN` moves back to `ACC_LOCKED` on 0x00. The latch sequencer is also a two-state machine. `LATCH_IDLE` moves to `LATCH_ARMED` on a latch-region write of 0x00. `LATCH_ARMED` fires the copy on a write of 0x01 and returns to `LATCH_IDLE`. Any other value returns it to `LATCH_IDLE`, except a further 0x00, which keeps it armed.

Top module: `rtc_bank_window`

## Requirements
- R1: After reset the gate is locked, the window reads 0xFF, and all live counters, snapshot fields, halt and carry are zero.
- R2: Writing 0x0A to the enable region opens the window. Writing 0x00 closes it. Any other value leaves the gate as it is.
- R3: While the gate is locked, window reads return 0xFF and window writes change no counter.
- R4: Select codes map the window as follows: 0x08 seconds, 0x09 minutes, 0x0A hours, 0x0B day bits 7:0, 0x0C control. Any other code reads 0xFF, and writes through it are ignored.
- R5: A latch-region write of 0x00 followed directly by 0x01 copies the live counters into the snapshot. Window reads return the snapshot, not the live value. A 0x01 not preceded by 0x00 does not copy.
- R6: Each second step follows TICKS_PER_SEC base ticks. Seconds count 0 to 59, and a wrap from 59 to 0 increments the minutes.
- R7: Minutes count 0 to 59 and carry into the hours. Hours count 0 to 23 and carry into the day count.
- R8: The day count is 9 bits. Bits 7:0 sit in code 0x0B and bit 8 sits in bit 0 of code 0x0C. A step from 511 wraps the count to 0 and sets the carry, which is bit 7 of code 0x0C.
- R9: The carry stays set through further counting. It clears only when software writes 0 to bit 7 of the control register.
- R10: While the halt bit (bit 6 of the control register) is 1, base ticks advance neither the seconds nor the sub-second phase.
- R11: A window write loads the live counter directly. A write to seconds also restarts the sub-second phase at zero. A write takes priority over a tick in the same cycle.
- R12: Control-register bits 5:1 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle pulse, TICKS_PER_SEC per second |
| bus_wr | input | 1 | Bus write strobe |
| bus_region | input | 2 | 0 enable, 1 bank select, 2 latch, 3 data window |
| bus_wdata | input | 8 | Bus write data |
| rd_data | output | 8 | Window read data (snapshot of the selected register) |

## Verification
The assertions assume that software writes in-range values: seconds and minutes at most 59, and hours at most 23. The range checks on the live counters only hold under that assumption. They also assume that bus writes and base ticks arrive as single-cycle strobes. The stimulus loads only legal times, such as 23:59:59 on day 511, and drives every write and tick from the falling clock edge. It never overlaps a tick with a write, so each expected value follows from a count of ticks alone.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DAY_W = 9;

    typedef enum logic [1:0] {
        RGN_ENABLE = 2'd0,
        RGN_BANK   = 2'd1,
        RGN_LATCH  = 2'd2,
        RGN_WINDOW = 2'd3
    } region_e;

    typedef enum logic {
        ACC_LOCKED = 1'b0,
        ACC_OPEN   = 1'b1
    } acc_state_e;

    typedef enum logic {
        LATCH_IDLE  = 1'b0,
        LATCH_ARMED = 1'b1
    } latch_state_e;

    localparam logic [7:0] CODE_BASE  = 8'h08;
    localparam int         NUM_FIELDS = 5;
    localparam logic [7:0] KEY_OPEN   = 8'h0A;
    localparam logic [7:0] KEY_CLOSE  = 8'h00;
    localparam logic [7:0] LATCH_PRE  = 8'h00;
    localparam logic [7:0] LATCH_GO   = 8'h01;

    typedef struct packed {
        logic             carry;
        logic             halt;
        logic [DAY_W-1:0] day;
        logic [4:0]       hrs;
        logic [5:0]       mins;
        logic [5:0]       secs;
    } rtc_time_t;

endpackage

// File: rtl/rtc_access_ctl.sv
module rtc_access_ctl
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [1:0] bus_region,
    input  logic [7:0] bus_wdata,
    output logic       acc_open,
    output logic [7:0] bank_q,
    output logic       latch_fire
);

    acc_state_e   acc_q, acc_d;
    latch_state_e lat_q, lat_d;

    logic wr_enable, wr_bank, wr_latch;

    always_comb begin
        wr_enable = bus_wr && (bus_region == RGN_ENABLE);
        wr_bank   = bus_wr && (bus_region == RGN_BANK);
        wr_latch  = bus_wr && (bus_region == RGN_LATCH);
    end

    // access gate state register
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= ACC_LOCKED;
        else        acc_q <= acc_d;
    end

    always_comb begin
        acc_d = acc_q;
        unique case (acc_q)
            ACC_LOCKED: if (wr_enable && bus_wdata == KEY_OPEN)  acc_d = ACC_OPEN;
            ACC_OPEN:   if (wr_enable && bus_wdata == KEY_CLOSE) acc_d = ACC_LOCKED;
            default:    acc_d = ACC_LOCKED;
        endcase
    end

    // latch sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= LATCH_IDLE;
        else        lat_q <= lat_d;
    end

    always_comb begin
        lat_d      = lat_q;
        latch_fire = 1'b0;
        unique case (lat_q)
            LATCH_IDLE: begin
                if (wr_latch && bus_wdata == LATCH_PRE) lat_d = LATCH_ARMED;
            end
            LATCH_ARMED: begin
                if (wr_latch) begin
                    if (bus_wdata == LATCH_GO) begin
                        latch_fire = 1'b1;
                        lat_d      = LATCH_IDLE;
                    end else if (bus_wdata != LATCH_PRE) begin
                        lat_d = LATCH_IDLE;
                    end
                end
            end
            default: lat_d = LATCH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       bank_q <= 8'h00;
        else if (wr_bank) bank_q <= bus_wdata;
    end

    assign acc_open = (acc_q == ACC_OPEN);

endmodule

// File: rtl/rtc_counters.sv
module rtc_counters
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  base_tick,
    input  logic [NUM_FIELDS-1:0] wr_sel,
    input  logic [7:0]            wr_data,
    output rtc_time_t             live
);

    localparam int          PRE_W    = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_SEC - 1);
    localparam logic [5:0]  SEC_LAST = 6'd59;
    localparam logic [5:0]  MIN_LAST = 6'd59;
    localparam logic [4:0]  HRS_LAST = 5'd23;

    rtc_time_t        cur_q, cur_d;
    logic [PRE_W-1:0] pre_q, pre_d;
    logic             sec_step;

    always_comb begin
        cur_d    = cur_q;
        pre_d    = pre_q;
        sec_step = 1'b0;
        if (|wr_sel) begin
            if (wr_sel[0]) begin
                cur_d.secs = wr_data[5:0];
                pre_d      = '0;
            end
            if (wr_sel[1]) cur_d.mins     = wr_data[5:0];
            if (wr_sel[2]) cur_d.hrs      = wr_data[4:0];
            if (wr_sel[3]) cur_d.day[7:0] = wr_data;
            if (wr_sel[4]) begin
                cur_d.day[DAY_W-1] = wr_data[0];
                cur_d.halt         = wr_data[6];
                cur_d.carry        = wr_data[7];
            end
        end else if (base_tick && !cur_q.halt) begin
            if (pre_q == PRE_LAST) begin
                pre_d    = '0;
                sec_step = 1'b1;
            end else begin
                pre_d = pre_q + 1'b1;
            end
        end

        if (sec_step) begin
            if (cur_q.secs != SEC_LAST) begin
                cur_d.secs = cur_q.secs + 6'd1;
            end else begin
                cur_d.secs = '0;
                if (cur_q.mins != MIN_LAST) begin
                    cur_d.mins = cur_q.mins + 6'd1;
                end else begin
                    cur_d.mins = '0;
                    if (cur_q.hrs != HRS_LAST) begin
                        cur_d.hrs = cur_q.hrs + 5'd1;
                    end else begin
                        cur_d.hrs = '0;
                        cur_d.day = cur_q.day + 1'b1;
                        if (&cur_q.day) cur_d.carry = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            pre_q <= '0;
        end else begin
            cur_q <= cur_d;
            pre_q <= pre_d;
        end
    end

    assign live = cur_q;

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       latch_fire,
    input  rtc_time_t  live,
    input  logic       acc_open,
    input  logic [7:0] bank_q,
    output rtc_time_t  snap,
    output logic [7:0] rd_data
);

    always_ff @(posedge clk) begin
        if (!rst_n)          snap <= '0;
        else if (latch_fire) snap <= live;
    end

    always_comb begin
        rd_data = 8'hFF;
        if (acc_open) begin
            case (bank_q)
                CODE_BASE + 8'd0: rd_data = {2'b00, snap.secs};
                CODE_BASE + 8'd1: rd_data = {2'b00, snap.mins};
                CODE_BASE + 8'd2: rd_data = {3'b000, snap.hrs};
                CODE_BASE + 8'd3: rd_data = snap.day[7:0];
                CODE_BASE + 8'd4: rd_data = {snap.carry, snap.halt, 5'b00000, snap.day[DAY_W-1]};
                default:          rd_data = 8'hFF;
            endcase
        end
    end

endmodule

// File: rtl/rtc_bank_window.sv
module rtc_bank_window
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_tick,
    input  logic       bus_wr,
    input  logic [1:0] bus_region,
    input  logic [7:0] bus_wdata,
    output logic [7:0] rd_data
);

    logic                  acc_open;
    logic [7:0]            bank_q;
    logic                  latch_fire;
    logic                  win_wr;
    logic [NUM_FIELDS-1:0] wr_sel;
    rtc_time_t             live;
    rtc_time_t             snap;

    rtc_access_ctl u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_region (bus_region),
        .bus_wdata  (bus_wdata),
        .acc_open   (acc_open),
        .bank_q     (bank_q),
        .latch_fire (latch_fire)
    );

    assign win_wr = bus_wr && acc_open && (bus_region == RGN_WINDOW);

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_sel
        assign wr_sel[g] = win_wr && (bank_q == CODE_BASE + 8'(g));
    end

    rtc_counters #(
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .wr_sel    (wr_sel),
        .wr_data   (bus_wdata),
        .live      (live)
    );

    rtc_snapshot u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_fire (latch_fire),
        .live       (live),
        .acc_open   (acc_open),
        .bank_q     (bank_q),
        .snap       (snap),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/rtc_bank_window_chk.sv
module rtc_bank_window_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_open,
    input logic [7:0] bank_q,
    input logic [7:0] rd_data,
    input logic [4:0] wr_sel,
    input logic       latch_fire,
    input logic [5:0] live_secs,
    input logic [5:0] live_mins,
    input logic [4:0] live_hrs,
    input logic       live_halt,
    input logic       live_carry,
    input logic [5:0] snap_secs
);

    // R3
    locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_open |-> rd_data == 8'hFF);

    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_fire |=> $stable(snap_secs));

    // R6
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_secs <= 6'd59);

    // R7
    time_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_mins <= 6'd59 && live_hrs <= 5'd23);

    // R9
    carry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_carry && !wr_sel[4]) |=> live_carry);

    // R10
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_halt && wr_sel == 5'b0) |=> $stable(live_secs));

    // R12
    ctrl_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_open && bank_q == 8'h0C) |-> rd_data[5:1] == 5'b0);

endmodule

bind rtc_bank_window rtc_bank_window_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_open   (acc_open),
    .bank_q     (bank_q),
    .rd_data    (rd_data),
    .wr_sel     (wr_sel),
    .latch_fire (latch_fire),
    .live_secs  (live.secs),
    .live_mins  (live.mins),
    .live_hrs   (live.hrs),
    .live_halt  (live.halt),
    .live_carry (live.carry),
    .snap_secs  (snap.secs)
);

// File: tb/tb_rtc_bank_window.sv
module tb_rtc_bank_window;

    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 4;
    localparam logic [1:0] R_EN = 2'd0, R_BANK = 2'd1, R_LATCH = 2'd2, R_WIN = 2'd3;
    localparam logic [7:0] C_SEC = 8'h08, C_MIN = 8'h09, C_HRS = 8'h0A, C_DLO = 8'h0B, C_CTL = 8'h0C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_region = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] rd_data;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_bank_window #(.TICKS_PER_SEC(TPS)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_tick  (base_tick),
        .bus_wr     (bus_wr),
        .bus_region (bus_region),
        .bus_wdata  (bus_wdata),
        .rd_data    (rd_data)
    );

    // monitor / scoreboard
    initial begin
        forever begin
            @(chk_ev);
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (rd_data !== e) begin
                    n_fail++;
                    $display("FAIL %s: rd_data=%h expected %h", t, rd_data, e);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] rgn, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_region = rgn; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] code, input logic [7:0] d);
        wr(R_BANK, code);
        wr(R_WIN, d);
    endtask

    task automatic latch();
        wr(R_LATCH, 8'h00);
        wr(R_LATCH, 8'h01);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); base_tick = 1'b1;
            @(negedge clk); base_tick = 1'b0;
        end
    endtask

    task automatic expect_rd(input logic [7:0] code, input logic [7:0] e, input string t);
        wr(R_BANK, code);
        exp_q.push_back(e);
        tag_q.push_back(t);
        -> chk_ev;
        @(negedge clk);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 / R3: locked after reset
        expect_rd(C_SEC, 8'hFF, "R1 locked read after reset");
        wr(R_EN, 8'h0A);
        expect_rd(C_SEC, 8'h00, "R1 reset snapshot seconds");
        latch();
        expect_rd(C_CTL, 8'h00, "R1 reset control");
        // R2: other value keeps it open
        wr(R_EN, 8'h05);
        expect_rd(C_HRS, 8'h00, "R2 gate stays open on other value");

        // R6 / R11 / R5
        wreg(C_SEC, 8'd58);
        ticks(TPS);
        wreg(C_MIN, 8'd5);
        expect_rd(C_MIN, 8'h00, "R5 read returns snapshot not live");
        latch();
        expect_rd(C_SEC, 8'd59, "R6 seconds step after TPS ticks");
        expect_rd(C_MIN, 8'd5, "R11 minute write loads live");
        ticks(TPS);
        latch();
        expect_rd(C_SEC, 8'd0, "R6 seconds wrap");
        expect_rd(C_MIN, 8'd6, "R6 minute carry");

        // R7 / R8: full rollover from 23:59:59 day 511
        wreg(C_SEC, 8'd59);
        wreg(C_MIN, 8'd59);
        wreg(C_HRS, 8'd23);
        wreg(C_DLO, 8'hFF);
        wreg(C_CTL, 8'h01);
        latch();
        expect_rd(C_CTL, 8'h01, "R8 day bit 8 in control bit 0");
        ticks(TPS);
        latch();
        expect_rd(C_MIN, 8'd0, "R7 minutes wrap");
        expect_rd(C_HRS, 8'd0, "R7 hours wrap");
        expect_rd(C_DLO, 8'h00, "R8 day wraps to 0");
        expect_rd(C_CTL, 8'h80, "R8 carry set on day overflow");

        // R9: sticky carry
        ticks(TPS * 2);
        latch();
        expect_rd(C_CTL, 8'h80, "R9 carry stays set");
        expect_rd(C_SEC, 8'd2, "R9 counting continues");
        wreg(C_CTL, 8'h00);
        latch();
        expect_rd(C_CTL, 8'h00, "R9 carry cleared by write");

        // R12 / R10
        wreg(C_CTL, 8'hFF);
        latch();
        expect_rd(C_CTL, 8'hC1, "R12 unused control bits read 0");
        ticks(TPS * 2);
        latch();
        expect_rd(C_SEC, 8'd2, "R10 halt freezes seconds");
        wreg(C_CTL, 8'h00);

        // R11: seconds write restarts phase
        wreg(C_SEC, 8'd10);
        ticks(2);
        wreg(C_SEC, 8'd20);
        ticks(TPS - 1);
        latch();
        expect_rd(C_SEC, 8'd20, "R11 phase restarted by seconds write");
        ticks(1);
        latch();
        expect_rd(C_SEC, 8'd21, "R11 step after full phase");

        // R4: unmapped codes
        expect_rd(8'h07, 8'hFF, "R4 code below range reads FF");
        wreg(8'h0D, 8'h33);
        expect_rd(8'h0D, 8'hFF, "R4 code above range reads FF");
        latch();
        expect_rd(C_SEC, 8'd21, "R4 unmapped write ignored");

        // R5: 0x01 alone, or broken sequence, does not latch
        wreg(C_SEC, 8'd40);
        wr(R_LATCH, 8'h01);
        expect_rd(C_SEC, 8'd21, "R5 lone 0x01 does not latch");
        wr(R_LATCH, 8'h00);
        wr(R_LATCH, 8'h02);
        wr(R_LATCH, 8'h01);
        expect_rd(C_SEC, 8'd21, "R5 broken sequence does not latch");

        // R3 / R2: locked writes ignored
        wr(R_EN, 8'h00);
        wreg(C_SEC, 8'd5);
        expect_rd(C_SEC, 8'hFF, "R2 close on 0x00");
        wr(R_EN, 8'h0A);
        latch();
        expect_rd(C_SEC, 8'd40, "R3 locked write ignored");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule